// File: doc/BRIEF.md
# In-System Programming Serial Target

This block is the device end of a four-byte serial programming port. It runs on the system clock and treats the incoming serial clock, data-in line and an active-high resync input as asynchronous signals. Each of them passes through a two-stage synchroniser. A serial-clock level is accepted only after it has held for a minimum number of system clocks, and that minimum is chosen by a static speed-range input. Accepted rising edges shift data-in into the receiver. Accepted falling edges advance the byte presented on MISO.

Instructions are always four bytes long. The port stays closed until a correctly framed enable instruction arrives. While the enable instruction is received, its second byte is echoed back on MISO during the third byte, so the programmer can confirm that framing is aligned. Once the port is open, the block decodes reads, writes and a whole-chip erase against two small internal byte arrays: a program array and a data array. A resync pulse taken while the serial clock is low restarts the framing and closes the port.

Top module: `isp_target`

## Requirements
- R1: An instruction is four bytes, sent MSB first. During the second, third and fourth byte, MISO returns the byte received just before, MSB first. The one exception is the fourth byte of an enabled read. The first byte after reset returns 0x00.
- R2: MISO changes only after an accepted falling edge of the serial clock. MOSI is taken on accepted rising edges.
- R3: A serial-clock level is accepted once it has been seen on 3 consecutive system clocks when `fastClk` is 0, or on 4 consecutive system clocks when `fastClk` is 1. A shorter pulse shifts nothing.
- R4: The enable instruction is 0xAC 0x53 xx xx. `progMode` goes high when its fourth byte completes. The 0x53 is echoed during the third byte. If the second byte is any other value, `progMode` stays low, but all four bytes are still consumed.
- R5: While `progMode` is low, every instruction other than the enable instruction has no effect on either array. A read returns the echo of its third byte instead of array data.
- R6: Program read 0x20 xx A xx returns the program array byte at A modulo the array depth (64 by default) as the fourth response byte.
- R7: Program write 0x40 xx A D stores the bitwise AND of D and the old content at A modulo 64.
- R8: Data write 0xC0 xx A D replaces the byte at A modulo the data depth (32 by default) with D, with no prior erase needed. Data read 0xA0 xx A xx returns that byte.
- R9: Both arrays hold 0xFF after reset. The erase instruction 0xAC 0x80 xx xx, taken while enabled, sets every byte of both arrays to 0xFF.
- R10: A `progRst` high level held for at least 2 system clocks while the serial clock is low clears the bit and byte counters and drives `progMode` low. A 1-clock pulse has no effect.
- R11: While `rstN` is low, `progMode` and `miso` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| progRst | input | 1 | Asynchronous active-high resync request |
| fastClk | input | 1 | Static speed range: 1 selects the longer minimum phase |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial response data |
| progMode | output | 1 | High while the programming port is enabled |

## Verification
The bench injects short serial-clock pulses just below and just at the qualification threshold in both speed ranges. A filter that is off by one cycle would shift a stray bit, which breaks the framing of the following enable instruction. It sends an enable with a wrong second byte and then one with the correct byte, and checks the echo on the third response byte. An echo taken from the wrong byte, or an enable that does not wait for all four bytes, shows up at once. It rewrites the same program location to show the AND behaviour, and rewrites a data location to show the overwrite. It uses an address above the array depth to check the wrap. It also cuts a frame short with a resync pulse and sends a 1-clock resync pulse, so counters that are not cleared or a pulse that is not qualified would misalign the next enable.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [7:0] OP_ENABLE  = 8'hAC;
  localparam logic [7:0] SYNC_BYTE  = 8'h53;
  localparam logic [7:0] ERASE_BYTE = 8'h80;
  localparam logic [7:0] OP_PREAD   = 8'h20;
  localparam logic [7:0] OP_PWRITE  = 8'h40;
  localparam logic [7:0] OP_DREAD   = 8'hA0;
  localparam logic [7:0] OP_DWRITE  = 8'hC0;

  typedef struct packed {
    logic shiftIn;   // accepted rising edge
    logic shiftOut;  // accepted falling edge
    logic byteDone;  // eighth rising edge of a byte
    logic loadRead;  // present array data as next response byte
    logic selData;   // read from data array instead of program array
    logic doPWrite;
    logic doDWrite;
    logic doErase;
    logic clearAll;  // qualified resync
  } strobe_t;
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
  import isp_pkg::*;
#(
  parameter int MIN_SLOW = 3,
  parameter int MIN_FAST = 4,
  parameter int RST_MIN  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fastClk,
  input  logic       sckS,
  input  logic       rstS,
  input  logic [7:0] b0,
  input  logic [7:0] b1,
  output strobe_t    stb,
  output logic [1:0] byteCnt,
  output logic       progMode
);
  localparam int RW = $clog2(MIN_FAST + 1);
  localparam int QW = $clog2(RST_MIN + 1);

  logic          sckLvl;
  logic [RW-1:0] runCnt;
  logic [RW-1:0] minLen;
  logic          mismatch, accept, rise, fall;
  logic [QW-1:0] rstCnt;
  logic          rstHold, clearAll;
  logic [2:0]    bitCnt;
  logic          byteDone, lastByte, isEnable, isErase;

  assign minLen   = fastClk ? RW'(MIN_FAST) : RW'(MIN_SLOW);
  assign mismatch = sckS != sckLvl;
  assign accept   = mismatch && (runCnt == minLen - RW'(1));
  assign rise     = accept && sckS && !rstS;
  assign fall     = accept && !sckS && !rstS;

  // phase qualification: a new level must persist minLen clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckLvl <= 1'b0;
      runCnt <= '0;
    end else if (!mismatch || accept) begin
      runCnt <= '0;
      if (accept) sckLvl <= sckS;
    end else begin
      runCnt <= runCnt + RW'(1);
    end
  end

  // resync qualification: progRst high with the clock low for RST_MIN clocks
  assign rstHold  = rstS && !sckLvl;
  assign clearAll = rstHold && (rstCnt == QW'(RST_MIN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstCnt <= '0;
    else if (!rstHold) rstCnt <= '0;
    else if (rstCnt != QW'(RST_MIN)) rstCnt <= rstCnt + QW'(1);
  end

  assign byteDone = rise && (bitCnt == 3'd7);
  assign lastByte = byteDone && (byteCnt == 2'd3);
  assign isEnable = (b0 == OP_ENABLE) && (b1 == SYNC_BYTE);
  assign isErase  = (b0 == OP_ENABLE) && (b1 == ERASE_BYTE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      byteCnt  <= '0;
      progMode <= 1'b0;
    end else if (clearAll) begin
      bitCnt   <= '0;
      byteCnt  <= '0;
      progMode <= 1'b0;
    end else begin
      if (rise) bitCnt <= bitCnt + 3'd1;
      if (byteDone) byteCnt <= byteCnt + 2'd1;
      if (lastByte && isEnable) progMode <= 1'b1;
    end
  end

  always_comb begin
    stb          = '0;
    stb.shiftIn  = rise;
    stb.shiftOut = fall;
    stb.byteDone = byteDone;
    stb.clearAll = clearAll;
    stb.selData  = (b0 == OP_DREAD);
    stb.loadRead = byteDone && (byteCnt == 2'd2) && progMode &&
                   ((b0 == OP_PREAD) || (b0 == OP_DREAD));
    stb.doPWrite = lastByte && progMode && (b0 == OP_PWRITE);
    stb.doDWrite = lastByte && progMode && (b0 == OP_DWRITE);
    stb.doErase  = lastByte && progMode && isErase;
  end
endmodule

// File: rtl/isp_dpath.sv
module isp_dpath
  import isp_pkg::*;
#(
  parameter int PM_DEPTH = 64,
  parameter int DM_DEPTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic       mosiS,
  input  logic [1:0] byteCnt,
  output logic [7:0] b0,
  output logic [7:0] b1,
  output logic       miso
);
  localparam int PAW = $clog2(PM_DEPTH);
  localparam int DAW = $clog2(DM_DEPTH);

  logic [7:0] pmem [PM_DEPTH];
  logic [7:0] dmem [DM_DEPTH];
  logic [7:0] rxShift, b2, txReg, newByte, readData;
  logic       misoR;

  assign newByte  = {rxShift[6:0], mosiS};
  assign readData = stb.selData ? dmem[newByte[DAW-1:0]] : pmem[newByte[PAW-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      b0      <= '0;
      b1      <= '0;
      b2      <= '0;
      txReg   <= '0;
      misoR   <= 1'b0;
    end else begin
      if (stb.shiftIn) rxShift <= newByte;
      if (stb.byteDone) begin
        case (byteCnt)
          2'd0:    b0 <= newByte;
          2'd1:    b1 <= newByte;
          2'd2:    b2 <= newByte;
          default: ;
        endcase
        txReg <= stb.loadRead ? readData : newByte;
      end else if (stb.shiftOut) begin
        misoR <= txReg[7];
        txReg <= {txReg[6:0], 1'b0};
      end
    end
  end

  // program array: bits can only be cleared by a write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PM_DEPTH; i++) pmem[i] <= 8'hFF;
    end else if (stb.doErase) begin
      for (int i = 0; i < PM_DEPTH; i++) pmem[i] <= 8'hFF;
    end else if (stb.doPWrite) begin
      pmem[b2[PAW-1:0]] <= pmem[b2[PAW-1:0]] & newByte;
    end
  end

  // data array: write erases the location itself
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DM_DEPTH; i++) dmem[i] <= 8'hFF;
    end else if (stb.doErase) begin
      for (int i = 0; i < DM_DEPTH; i++) dmem[i] <= 8'hFF;
    end else if (stb.doDWrite) begin
      dmem[b2[DAW-1:0]] <= newByte;
    end
  end

  assign miso = misoR;
endmodule

// File: rtl/isp_target.sv
module isp_target
  import isp_pkg::*;
#(
  parameter int PM_DEPTH    = 64,
  parameter int DM_DEPTH    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic progRst,
  input  logic fastClk,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic progMode
);
  strobe_t    stb;
  logic [2:0] syncOut;
  logic       sckSync, mosiSync, rstSync;
  logic [7:0] b0, b1;
  logic [1:0] byteCnt;

  isp_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .din({sck, mosi, progRst}), .dout(syncOut)
  );
  assign {sckSync, mosiSync, rstSync} = syncOut;

  isp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .fastClk(fastClk), .sckS(sckSync), .rstS(rstSync),
    .b0(b0), .b1(b1), .stb(stb), .byteCnt(byteCnt), .progMode(progMode)
  );

  isp_dpath #(.PM_DEPTH(PM_DEPTH), .DM_DEPTH(DM_DEPTH)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .mosiS(mosiSync), .byteCnt(byteCnt),
    .b0(b0), .b1(b1), .miso(miso)
  );
endmodule

// File: rtl/isp_target_chk.sv
module isp_target_chk
  import isp_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       fastClk,
  input logic       sckS,
  input strobe_t    stb,
  input logic [1:0] byteCnt,
  input logic       progMode,
  input logic       miso
);
  // R11
  rst_state_chk: assert property (@(posedge clk) !rstN |=> (!progMode && !miso));

  // R2
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.shiftOut |=> $stable(miso));

  // R3
  rise_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftIn |-> (sckS && $past(sckS) && $past(sckS, 2)));

  // R3
  fall_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftOut |-> (!sckS && !$past(sckS) && !$past(sckS, 2)));

  // R3
  fast_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shiftIn && fastClk) |-> $past(sckS, 3));

  // R4
  enable_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progMode) |-> $past(stb.byteDone && byteCnt == 2'd3));

  // R10
  resync_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAll |=> (!progMode && byteCnt == 2'd0));
endmodule

bind isp_target isp_target_chk i_chk (
  .clk(clk), .rstN(rstN), .fastClk(fastClk), .sckS(sckSync), .stb(stb),
  .byteCnt(byteCnt), .progMode(progMode), .miso(miso)
);

// File: tb/test_isp_target.sv
module test_isp_target;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progRst = 1'b0;
  logic fastClk = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso, progMode;

  int nChk = 0;
  int nBad = 0;
  logic r2Bad = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  isp_target i_isp_target (
    .clk(clk), .rstN(rstN), .progRst(progRst), .fastClk(fastClk),
    .sck(sck), .mosi(mosi), .miso(miso), .progMode(progMode)
  );

  // {instruction, expected fourth response byte}
  localparam logic [39:0] VEC [15] = '{
    {32'h40_00_05_3C, 8'h05},  // R7 first write
    {32'h20_00_05_00, 8'h3C},  // R6
    {32'h40_00_05_F0, 8'h05},  // R7 second write
    {32'h20_00_05_00, 8'h30},  // R7 AND result
    {32'hC0_00_07_3C, 8'h07},  // R8
    {32'hC0_00_07_F0, 8'h07},  // R8 overwrite
    {32'hA0_00_07_00, 8'hF0},  // R8
    {32'hA0_00_05_00, 8'hFF},  // R8 separate array
    {32'h20_00_07_00, 8'hFF},  // R6
    {32'h40_00_46_12, 8'h46},  // R7 wraps to 6
    {32'h20_00_06_00, 8'h12},  // R6
    {32'hAC_80_00_00, 8'h00},  // R9 erase
    {32'h20_00_05_00, 8'hFF},  // R9
    {32'hA0_00_07_00, 8'hFF},  // R9
    {32'h20_00_06_00, 8'hFF}   // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx);
    logic held;
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      sck = 1'b0;
      clks(H);
      rx[i] = miso;
      held = miso;
      sck = 1'b1;
      clks(H);
      if (miso !== held) r2Bad = 1'b1;
    end
    sck = 1'b0;
  endtask

  task automatic instr(input logic [31:0] cmd, output logic [31:0] resp);
    for (int k = 3; k >= 0; k--) begin
      logic [7:0] r;
      spiByte(cmd[k*8 +: 8], r);
      resp[k*8 +: 8] = r;
    end
    clks(H);
  endtask

  task automatic pulseRst(input int n);
    progRst = 1'b1;
    clks(n);
    progRst = 1'b0;
    clks(6);
  endtask

  task automatic glitch(input int n, input logic d);
    mosi = d;
    sck = 1'b1;
    clks(n);
    sck = 1'b0;
    clks(H);
  endtask

  initial begin
    logic [31:0] rsp;
    clks(3);
    check("R11 progMode in reset", 32'(progMode), 0);
    check("R11 miso in reset", 32'(miso), 0);
    rstN = 1'b1;
    clks(3);

    // closed port
    instr(32'h40_00_03_00, rsp);
    check("R1 first response byte", 32'(rsp[31:24]), 0);
    instr(32'h20_00_03_00, rsp);
    check("R5 read echoes while closed", 32'(rsp[7:0]), 32'h03);
    instr(32'hAC_52_00_00, rsp);
    check("R4 echo of bad sync byte", 32'(rsp[15:8]), 32'h52);
    check("R4 bad sync stays closed", 32'(progMode), 0);
    instr(32'hAC_53_00_00, rsp);
    check("R4 echo of sync byte", 32'(rsp[15:8]), 32'h53);
    check("R4 enable opens port", 32'(progMode), 1);
    instr(32'h20_00_03_00, rsp);
    check("R5 write while closed ignored", 32'(rsp[7:0]), 32'hFF);
    check("R9 reset content", 32'(rsp[7:0]), 32'hFF);

    foreach (VEC[v]) begin
      instr(VEC[v][39:8], rsp);
      check($sformatf("R6/R7/R8/R9 vector %0d", v), 32'(rsp[7:0]), 32'(VEC[v][7:0]));
      check("R1 echo of byte one", 32'(rsp[23:16]), 32'(VEC[v][39:32]));
      check("R1 echo of byte two", 32'(rsp[15:8]), 32'(VEC[v][31:24]));
    end

    // resync
    pulseRst(1);
    check("R10 short pulse ignored", 32'(progMode), 1);
    pulseRst(2);
    check("R10 pulse closes port", 32'(progMode), 0);
    instr(32'hAC_53_00_00, rsp);
    spiByte(8'h20, rsp[7:0]);
    spiByte(8'h00, rsp[7:0]);
    clks(H);
    pulseRst(2);
    check("R10 mid-frame resync closes", 32'(progMode), 0);
    instr(32'hAC_53_00_00, rsp);
    check("R10 framing restarts", 32'(progMode), 1);

    // phase qualification, slow range
    pulseRst(2);
    glitch(2, 1'b1);
    instr(32'hAC_53_00_00, rsp);
    check("R3 slow 2-clock pulse ignored", 32'(progMode), 1);
    pulseRst(2);
    glitch(3, 1'b1);
    instr(32'hAC_53_00_00, rsp);
    check("R3 slow 3-clock pulse taken", 32'(progMode), 0);

    // fast range
    fastClk = 1'b1;
    pulseRst(2);
    glitch(3, 1'b1);
    instr(32'hAC_53_00_00, rsp);
    check("R3 fast 3-clock pulse ignored", 32'(progMode), 1);
    pulseRst(2);
    glitch(4, 1'b1);
    instr(32'hAC_53_00_00, rsp);
    check("R3 fast 4-clock pulse taken", 32'(progMode), 0);
    pulseRst(2);
    instr(32'hAC_53_00_00, rsp);
    instr(32'hC0_00_03_5A, rsp);
    instr(32'hA0_00_03_00, rsp);
    check("R8 fast range read", 32'(rsp[7:0]), 32'h5A);

    check("R2 miso steady in high phase", 32'(r2Bad), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nBad++;
        nChk++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule